// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a small memory-mapped register interface. Software arms it by programming a reload value and a clock divider, then enabling it. From then on, software must write a special restart word before the count runs out. If the count does run out, the block either drives a reset pulse of programmable length to the rest of the chip or raises a level interrupt. The choice depends on two enable bits.

Stray writes are guarded against in two ways. The mode and counter-control registers change only when the write carries a fixed key pattern in its upper bits. The restart register acts only on one exact 32-bit word. The bus is a single-cycle interface: a byte address, a write strobe, a 32-bit write word, and a combinational read word.

The control core is a four-state machine. In ST_OFF the watchdog is disabled. In ST_RUN it counts down. In ST_PULSE it drives the reset output. In ST_HALT it has expired and is waiting. The transitions are as follows:
- Enable (ST_OFF to ST_RUN).
- Timeout with reset enabled (ST_RUN to ST_PULSE).
- Timeout with reset disabled (ST_RUN to ST_HALT).
- Pulse done (ST_PULSE to ST_HALT).
- Restart (ST_RUN, ST_PULSE or ST_HALT to ST_RUN, with a reload).
- Disable (any state to ST_OFF).

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the mode, control and status registers read 0, and the reset and interrupt outputs are low.
- R2: A write to offset 0x0 is accepted only when write data bits [23:12] equal 0xABC. The mode register holds the enable in bit 0, the reset-on-timeout enable in bit 1, the interrupt-on-timeout enable in bit 2 and the pulse-length select in bits [5:4], and it reads back at those positions. A write with any other key leaves the register unchanged.
- R3: A write to offset 0x4 is accepted only when bits [25:14] equal 0x248 (the word 0x00920000). The control register holds the 12-bit reload value in bits [13:2] and the divider select in bits [1:0], and it reads back at those positions. A write with a wrong key leaves it unchanged.
- R4: Divider select values 0, 1, 2 and 3 give one tick every 8, 64, 512 and 4096 clocks. The timeout comes reload × 2^SCALE_LOG2 ticks after the counter is loaded.
- R5: Writing exactly 0x00001999 to offset 0x8 while enabled reloads the counter and clears the expired condition. Any other value written there has no effect. Offset 0x8 reads as 0.
- R6: Bit 0 at offset 0xC reads 1 from timeout until a restart or a disable.
- R7: On timeout with reset enabled, the reset output goes high once, for 2^(sel+1) clocks (16 for select 3, 2 for select 0). After that the block holds in the expired state and gives no further pulse.
- R8: On timeout with the interrupt enabled, the interrupt output stays high until a restart or a disable. The interrupt stays low when only the reset path is enabled.
- R9: Clearing the enable bit with a keyed write stops the count, clears the status and drops both outputs. A restart word written while disabled is ignored.
- R10: A keyed mode write that sets the enable bit while it was clear loads the counter in that same clock and starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wdt_rst | output | 1 | Timeout reset pulse |
| wdt_irq | output | 1 | Timeout interrupt level |

## Verification
The state of the block shows up at its pins in three ways. A wrong state register shows as the status bit or the interrupt rising too early or too late, which is visible within one divider period of the expected edge. A wrong pulse-length counter shows as a reset pulse of the wrong width, which is visible within 16 clocks of the timeout. A key comparison that leaks lets an unkeyed write change the read-back value in the very next cycle, and a restart decode that leaks clears the interrupt in the next cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_PULSE, ST_HALT} wdg_state_e;

    localparam logic [3:0]  OFS_MODE  = 4'h0;
    localparam logic [3:0]  OFS_CTRL  = 4'h4;
    localparam logic [3:0]  OFS_KICK  = 4'h8;
    localparam logic [3:0]  OFS_STAT  = 4'hC;
    localparam logic [11:0] MODE_KEY  = 12'hABC;
    localparam logic [11:0] CTRL_KEY  = 12'h248;
    localparam logic [31:0] KICK_WORD = 32'h0000_1999;
    localparam int          RELOAD_W  = 12;

    typedef struct packed {
        logic [1:0] plen;
        logic       irq_en;
        logic       rst_en;
        logic       en;
    } mode_t;

    typedef struct packed {
        logic [RELOAD_W-1:0] reload;
        logic [1:0]          psel;
    } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  addr,
    input  logic        we,
    input  logic [31:0] wdata,
    input  logic        expired,
    output logic [31:0] rdata,
    output mode_t       mode_q,
    output ctrl_t       ctrl_q,
    output logic        start_p,
    output logic        kick_p
);
    logic mode_wr, ctrl_wr;

    assign mode_wr = we && (addr == OFS_MODE) && (wdata[23:12] == MODE_KEY);
    assign ctrl_wr = we && (addr == OFS_CTRL) && (wdata[25:14] == CTRL_KEY);
    assign start_p = mode_wr && wdata[0] && !mode_q.en;
    assign kick_p  = we && (addr == OFS_KICK) && (wdata == KICK_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (mode_wr) mode_q <= {wdata[5:4], wdata[2], wdata[1], wdata[0]};
            if (ctrl_wr) ctrl_q <= wdata[13:0];
        end
    end

    always_comb begin
        case (addr)
            OFS_MODE: rdata = {26'd0, mode_q.plen, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
            OFS_CTRL: rdata = {18'd0, ctrl_q};
            OFS_STAT: rdata = {31'd0, expired};
            default:  rdata = '0;
        endcase
    end

    assert_mode_key_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_MODE && wdata[23:12] != MODE_KEY) |=> $stable(mode_q));
    assert_ctrl_key_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CTRL && wdata[25:14] != CTRL_KEY) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int BASE_LOG2 = 3,
    parameter int STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clear,
    input  logic [1:0] psel,
    output logic       tick
);
    localparam int W = BASE_LOG2 + 3 * STEP_LOG2;

    logic [W-1:0] cnt;
    logic [W-1:0] lims [4];

    for (genvar g = 0; g < 4; g++) begin : g_lim
        assign lims[g] = W'((64'd1 << (BASE_LOG2 + STEP_LOG2 * g)) - 64'd1);
    end

    assign tick = run && !clear && (cnt == lims[psel]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (clear || !run)   cnt <= '0;
        else if (tick)            cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    assert_tick_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
#(
    parameter int SCALE_LOG2 = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  mode_t               mode,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                start_p,
    input  logic                kick_p,
    input  logic                tick,
    output logic                run,
    output logic                load,
    output logic                wdt_rst,
    output logic                wdt_irq,
    output logic                expired
);
    localparam int CW = RELOAD_W + SCALE_LOG2;

    wdg_state_e   state, nxt;
    logic [CW-1:0] cnt;
    logic [4:0]    pcnt;
    logic          timeout;

    assign load    = start_p || (kick_p && mode.en);
    assign timeout = (state == ST_RUN) && tick && (cnt <= CW'(1));

    always_comb begin
        nxt = state;
        if (load) begin
            nxt = ST_RUN;
        end else if (!mode.en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_OFF;
                ST_RUN:   if (timeout) nxt = mode.rst_en ? ST_PULSE : ST_HALT;
                ST_PULSE: if (pcnt == 5'd1) nxt = ST_HALT;
                ST_HALT:  nxt = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            if (load)                             cnt <= CW'(reload) << SCALE_LOG2;
            else if (state == ST_RUN && tick && cnt != '0) cnt <= cnt - 1'b1;
            if (timeout)                          pcnt <= 5'(5'd2 << mode.plen);
            else if (state == ST_PULSE && pcnt != '0) pcnt <= pcnt - 1'b1;
        end
    end

    always_comb begin
        run     = (state == ST_RUN);
        expired = (state == ST_PULSE) || (state == ST_HALT);
        wdt_rst = (state == ST_PULSE);
        wdt_irq = expired && mode.irq_en;
    end

    assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.en |=> (!wdt_rst && !wdt_irq && !expired));
    assert_kick_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_p && mode.en) |=> !expired);
    assert_timeout_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick));
    assert_pulse_ends_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wdt_rst) && mode.en && !$past(kick_p)) |-> expired);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int SCALE_LOG2    = 12,
    parameter int PRE_BASE_LOG2 = 3,
    parameter int PRE_STEP_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst,
    output logic        wdt_irq
);
    mode_t mode_q;
    ctrl_t ctrl_q;
    logic  start_p, kick_p, expired, run, load, tick;

    wdg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .expired(expired), .rdata(bus_rdata), .mode_q(mode_q), .ctrl_q(ctrl_q),
        .start_p(start_p), .kick_p(kick_p)
    );

    wdg_prescaler #(.BASE_LOG2(PRE_BASE_LOG2), .STEP_LOG2(PRE_STEP_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(load), .psel(ctrl_q.psel), .tick(tick)
    );

    wdg_fsm #(.SCALE_LOG2(SCALE_LOG2)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .reload(ctrl_q.reload),
        .start_p(start_p), .kick_p(kick_p), .tick(tick), .run(run), .load(load),
        .wdt_rst(wdt_rst), .wdt_irq(wdt_irq), .expired(expired)
    );
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst, wdt_irq;

    int tests = 0;
    int fails = 0;
    int pulse_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    keyed_watchdog #(.SCALE_LOG2(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq)
    );

    always @(negedge clk) if (wdt_rst) pulse_cnt++;

    // monitor: pop expected items and compare against the design
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, wdt_rst};
                2:       act = {31'd0, wdt_irq};
                default: act = pulse_cnt;
            endcase
            tests++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic chk(int kind, logic [3:0] a, logic [31:0] exp, string tag);
        item_t it;
        bus_addr = a;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(0, 4'h0, 32'h0, "R1 mode");
        chk(0, 4'h4, 32'h0, "R1 ctrl");
        chk(0, 4'hC, 32'h0, "R1 status");
        chk(1, 4'h0, 32'h0, "R1 rst");
        chk(2, 4'h0, 32'h0, "R1 irq");

        // R3 keyed control write and a rejected one
        wr(4'h4, 32'h0092_000C);
        chk(0, 4'h4, 32'h0000_000C, "R3 ctrl readback");
        wr(4'h4, 32'h0091_0014);
        chk(0, 4'h4, 32'h0000_000C, "R3 bad key ignored");

        // R10/R8/R4 interrupt timeout: 3*4 ticks * 8 clocks = 96
        wr(4'h0, 32'h00AB_C005);
        chk(0, 4'h0, 32'h0000_0005, "R2 mode readback");
        idle(78);
        chk(0, 4'hC, 32'h0, "R10 not yet expired");
        chk(2, 4'h0, 32'h0, "R8 irq low before timeout");
        idle(22);
        chk(0, 4'hC, 32'h1, "R6 status after timeout");
        chk(2, 4'h0, 32'h1, "R8 irq high");
        chk(1, 4'h0, 32'h0, "R8 no reset pulse");

        // R5 wrong restart word, then right one
        wr(4'h8, 32'h0000_1998);
        chk(2, 4'h0, 32'h1, "R5 wrong word ignored");
        wr(4'h8, 32'h0000_1999);
        chk(2, 4'h0, 32'h0, "R5 restart clears irq");
        chk(0, 4'hC, 32'h0, "R5 restart clears status");
        chk(0, 4'h8, 32'h0, "R5 restart reads zero");

        // R2 wrong mode key cannot disable
        wr(4'h0, 32'h00AB_B000);
        chk(0, 4'h0, 32'h0000_0005, "R2 bad key ignored");

        // R9 disable
        wr(4'h0, 32'h00AB_C000);
        idle(120);
        chk(0, 4'hC, 32'h0, "R9 disabled no expiry");
        chk(2, 4'h0, 32'h0, "R9 irq low");
        wr(4'h8, 32'h0000_1999);
        idle(120);
        chk(0, 4'hC, 32'h0, "R9 restart ignored when off");

        // R7 reset pulse, select 3: 1*4 ticks * 8 = 32 clocks
        wr(4'h4, 32'h0092_0004);
        pulse_cnt = 0;
        wr(4'h0, 32'h00AB_C033);
        idle(70);
        chk(3, 4'h0, 32'd16, "R7 pulse 16 clocks");
        chk(1, 4'h0, 32'h0, "R7 pulse ended");
        chk(0, 4'hC, 32'h1, "R7 status held");
        chk(2, 4'h0, 32'h0, "R8 irq off in reset mode");
        idle(60);
        chk(3, 4'h0, 32'd16, "R7 single pulse");

        // R7 pulse select 0
        wr(4'h0, 32'h00AB_C000);
        idle(2);
        pulse_cnt = 0;
        wr(4'h0, 32'h00AB_C003);
        idle(70);
        chk(3, 4'h0, 32'd2, "R7 pulse 2 clocks");

        // R4 divider select 1: 1*4 ticks * 64 = 256 clocks
        wr(4'h0, 32'h00AB_C000);
        wr(4'h4, 32'h0092_0005);
        wr(4'h0, 32'h00AB_C005);
        idle(238);
        chk(0, 4'hC, 32'h0, "R4 div64 before");
        idle(28);
        chk(0, 4'hC, 32'h1, "R4 div64 after");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule